// File: doc/BRIEF.md
# Cascadable Magnitude Comparator with Maximum

This block ranks two unsigned operands of `W` bits (four by default) against each other and reports the result on three one-hot flags: operand A larger, operands equal, or operand A smaller. It also drives out whichever operand is larger. It contains no registers. The outputs follow the inputs through combinational logic alone.

The ranking does not use a subtractor. Every bit position gets an XNOR equality term. A prefix of those terms, starting at the most significant bit, marks where the first difference sits. At that position the bit pair decides the result. When every bit ties, the three flags take their values from cascade inputs driven by a lower-significance stage. Several instances can therefore be chained into a wider comparator. In such a chain the least significant stage ties its cascade inputs to "equal", and its neighbour above reads its flags as cascade inputs. Four default stages chained this way compare 16-bit values.

The maximum output depends only on this stage's own operands. On a tie it returns A.

Top module: `mag_cmp_stage`

## Requirements
- R1: When `opa` > `opb` as unsigned values, the outputs are `gt_o`=1, `eq_o`=0 and `lt_o`=0, whatever the cascade inputs are.
- R2: When `opa` < `opb` as unsigned values, the outputs are `lt_o`=1, `gt_o`=0 and `eq_o`=0, whatever the cascade inputs are.
- R3: When `opa` == `opb`, `gt_o`, `eq_o` and `lt_o` equal `cas_gt_i`, `cas_eq_i` and `cas_lt_i` respectively.
- R4: The highest bit position where the operands differ decides the result, even when every lower bit favours the other operand (for example 1000 against 0111 gives `gt_o`=1).
- R5: When exactly one cascade input is high, exactly one of `gt_o`, `eq_o` and `lt_o` is high, for every operand pair.
- R6: `max_o` equals the larger of `opa` and `opb`, and equals `opa` when the two are equal.
- R7: Four stages can be chained into a 16-bit comparator. Stage k takes bits 4k+3..4k of each operand. Its cascade inputs come from the flags of stage k-1, and stage 0 has `cas_eq_i`=1 with the other two cascade inputs at 0. The flags of stage 3 then rank the full 16-bit values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | Operand A, unsigned |
| opb | input | W | Operand B, unsigned |
| cas_gt_i | input | 1 | Greater flag from the lower-significance stage |
| cas_eq_i | input | 1 | Equal flag from the lower-significance stage |
| cas_lt_i | input | 1 | Less flag from the lower-significance stage |
| gt_o | output | 1 | A ranks above B |
| eq_o | output | 1 | A and B rank equal |
| lt_o | output | 1 | A ranks below B |
| max_o | output | W | The larger operand; A on a tie |

## Verification
The bench runs through all 256 operand pairs, so a priority term left out or in the wrong place would show up as a wrong flag on some pair. For example, a design that let a lower bit win would call 1000 less than 0111. Equal pairs are run under all three cascade patterns. A design that ignored the cascade, or swapped two of its lines, would report "equal" or the wrong rank in a chain. A 16-bit chain of four stages is driven with directed and pseudo-random values, including values that differ only in the lowest nibble, which catches ties that are not passed up the chain. The maximum output is checked on every pair, which catches a select taken from the wrong flag.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } rank_t;
endpackage

// File: rtl/mag_cmp_biteq.sv
module mag_cmp_biteq #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] same
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign same[i] = ~(a[i] ^ b[i]);
  end
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] same,
  input  rank_t        cas,
  output rank_t        res,
  output logic         loc_lt
);
  logic [W:0]   above_tie;
  logic [W-1:0] win_a;
  logic [W-1:0] win_b;
  logic         all_tie;

  assign above_tie[W] = 1'b1;
  for (genvar i = W - 1; i >= 0; i--) begin : g_pri
    assign above_tie[i] = above_tie[i+1] & same[i];
    assign win_a[i]     = above_tie[i+1] & a[i] & ~b[i];
    assign win_b[i]     = above_tie[i+1] & ~a[i] & b[i];
  end
  assign all_tie = above_tie[0];

  assign loc_lt = |win_b;
  assign res.gt = (|win_a) | (all_tie & cas.gt);
  assign res.lt = (|win_b) | (all_tie & cas.lt);
  assign res.eq = all_tie & cas.eq;

  always_comb begin
    if (!$isunknown({a, b})) begin
      p_tie_rule_r3: assert (!(a == b) || (res == cas))
        else $error("tie does not copy cascade");
    end
  end
endmodule

// File: rtl/mag_cmp_maxsel.sv
module mag_cmp_maxsel #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         a_below,
  output logic [W-1:0] big
);
  assign big = a_below ? b : a;

  always_comb begin
    if (!$isunknown({a, b, a_below})) begin
      p_max_bound_r6: assert (big >= a && big >= b)
        else $error("max below an operand");
    end
  end
endmodule

// File: rtl/mag_cmp_stage.sv
module mag_cmp_stage
  import mag_cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cas_gt_i,
  input  logic         cas_eq_i,
  input  logic         cas_lt_i,
  output logic         gt_o,
  output logic         eq_o,
  output logic         lt_o,
  output logic [W-1:0] max_o
);
  logic [W-1:0] same;
  rank_t        cas;
  rank_t        res;
  logic         loc_lt;

  assign cas = '{gt: cas_gt_i, eq: cas_eq_i, lt: cas_lt_i};

  mag_cmp_biteq #(.W(W)) u_eq (.a(opa), .b(opb), .same(same));

  mag_cmp_chain #(.W(W)) u_chain (
    .a(opa), .b(opb), .same(same), .cas(cas), .res(res), .loc_lt(loc_lt)
  );

  mag_cmp_maxsel #(.W(W)) u_max (
    .a(opa), .b(opb), .a_below(loc_lt), .big(max_o)
  );

  assign gt_o = res.gt;
  assign eq_o = res.eq;
  assign lt_o = res.lt;

  always_comb begin
    if (!$isunknown({opa, opb, cas_gt_i, cas_eq_i, cas_lt_i})) begin
      p_gt_rank_r1: assert (!(opa > opb) || (gt_o && !eq_o && !lt_o))
        else $error("greater rank wrong");
      p_lt_rank_r2: assert (!(opa < opb) || (lt_o && !eq_o && !gt_o))
        else $error("less rank wrong");
      p_onehot_r5: assert (!$onehot({cas_gt_i, cas_eq_i, cas_lt_i}) ||
                           $onehot({gt_o, eq_o, lt_o}))
        else $error("flags not one-hot");
    end
  end
endmodule

// File: tb/sim_mag_cmp_stage.sv
module sim_mag_cmp_stage;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [3:0] opa, opb;
  logic cg, ce, cl;
  logic gt, eq, lt;
  logic [3:0] mx;

  mag_cmp_stage #(.W(4)) u0 (
    .opa(opa), .opb(opb), .cas_gt_i(cg), .cas_eq_i(ce), .cas_lt_i(cl),
    .gt_o(gt), .eq_o(eq), .lt_o(lt), .max_o(mx)
  );

  logic [15:0] wa, wb;
  logic [3:0] sg, se, sl;
  logic [3:0] smx [4];
  for (genvar k = 0; k < 4; k++) begin : g_ch
    mag_cmp_stage #(.W(4)) u_st (
      .opa(wa[4*k +: 4]), .opb(wb[4*k +: 4]),
      .cas_gt_i(k == 0 ? 1'b0 : sg[(k == 0) ? 0 : k-1]),
      .cas_eq_i(k == 0 ? 1'b1 : se[(k == 0) ? 0 : k-1]),
      .cas_lt_i(k == 0 ? 1'b0 : sl[(k == 0) ? 0 : k-1]),
      .gt_o(sg[k]), .eq_o(se[k]), .lt_o(sl[k]), .max_o(smx[k])
    );
  end

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic drive(input int a, input int b, input logic g, input logic e, input logic l);
    @(negedge clk);
    opa = a[3:0]; opb = b[3:0]; cg = g; ce = e; cl = l;
    #1;
  endtask

  task automatic t_idle;
    drive(0, 0, 1'b0, 1'b1, 1'b0);
    chk("R3 idle flags", {gt, eq, lt}, 3'b010);
    chk("R6 idle max", mx, 0);
  endtask

  task automatic t_exhaustive;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        drive(a, b, 1'b0, 1'b1, 1'b0);
        if (a > b)      chk("R1 greater", {gt, eq, lt}, 3'b100);
        else if (a < b) chk("R2 less", {gt, eq, lt}, 3'b001);
        else            chk("R3 equal", {gt, eq, lt}, 3'b010);
        chk("R6 max", mx, (a >= b) ? a : b);
      end
  endtask

  task automatic t_msb_wins;
    drive(4'b1000, 4'b0111, 1'b0, 1'b0, 1'b1);
    chk("R4 msb gt", {gt, eq, lt}, 3'b100);
    drive(4'b0100, 4'b1011, 1'b1, 1'b0, 1'b0);
    chk("R4 msb lt", {gt, eq, lt}, 3'b001);
    drive(4'b1101, 4'b1011, 1'b0, 1'b0, 1'b1);
    chk("R4 second bit", {gt, eq, lt}, 3'b100);
  endtask

  task automatic t_cascade;
    for (int a = 0; a < 16; a++) begin
      drive(a, a, 1'b1, 1'b0, 1'b0);
      chk("R3 tie gt", {gt, eq, lt}, 3'b100);
      drive(a, a, 1'b0, 1'b0, 1'b1);
      chk("R3 tie lt", {gt, eq, lt}, 3'b001);
      chk("R6 tie max", mx, a);
    end
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          drive(a, b, p == 0, p == 1, p == 2);
          chk("R5 onehot", int'($countones({gt, eq, lt})), 1);
        end
  endtask

  task automatic chain_one(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    wa = a; wb = b;
    #1;
    chk("R7 chain", {sg[3], se[3], sl[3]},
        (a > b) ? 3'b100 : (a < b) ? 3'b001 : 3'b010);
  endtask

  task automatic t_chain;
    chain_one(16'h1234, 16'h1234);
    chain_one(16'h1235, 16'h1234);
    chain_one(16'h1234, 16'h1235);
    chain_one(16'h8000, 16'h7FFF);
    chain_one(16'h0F00, 16'h0EFF);
    chain_one(16'hFFFF, 16'h0000);
    for (int i = 0; i < 300; i++) chain_one(16'($urandom), 16'($urandom));
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    opa = '0; opb = '0; cg = 1'b0; ce = 1'b1; cl = 1'b0;
    wa = '0; wb = '0;
    t_idle();
    t_exhaustive();
    t_msb_wins();
    t_cascade();
    t_chain();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule